// File: doc/BRIEF.md
# Layered Threshold Evaluator for Symmetric Boolean Functions

The block computes an arbitrary symmetric Boolean function of `N` one-bit inputs. A symmetric function depends only on how many inputs are 1, so software describes it with a table of `N+1` bits: bit `c` is the output when exactly `c` inputs are 1. The table is captured on a load strobe and held.

The evaluation is a two-layer linear-threshold network. The inputs feed only the first layer. For every maximal run of ones in the table, spanning counts `a..b`, the first layer places one unit that fires when the count is at least `a` and one unit that fires when the count is at most `b`. Inside the run both fire, and outside it exactly one fires. The single output unit adds up all first-layer outputs, subtracts one for each run plus one more, and fires when the result is not negative. The run edges are worked out from the stored table one clock after the load. The first-layer outputs are brought out for inspection. A parameter chooses a registered or a combinational function output.

Top module: `lts_symfunc_eval`

## Requirements
- R1: After reset the stored table is all zero: `funcOut` is 0 and every bit of `layerOut` is 0 for any `dataIn`.
- R2: A table on `tblIn` is captured at the rising edge where `loadTbl` is 1. The first-layer units still follow the previous table until the next rising edge. From that edge on they follow the new table.
- R3: With `REG_OUT=1`, after the rising edge that samples `dataIn`, `funcOut` equals bit `c` of the stored table, where `c` is the number of ones in that `dataIn`. This holds for every input pattern.
- R4: Runs are numbered from 0 in increasing count order. `layerOut[2r]` is 1 when the count is at least the first count of run `r`. `layerOut[2r+1]` is 1 when the count is at most the last count of run `r`. Slots with no run read 0. `layerOut` is combinational in `dataIn`.
- R5: A run that begins at count 0 has its lower unit at 1 for every input. A run that ends at count `N` has its upper unit at 1 for every input.
- R6: An all-zero table gives a constant 0 on `funcOut` and on all of `layerOut`.
- R7: While `loadTbl` is 0, changes on `tblIn` have no effect on the evaluated function.
- R8: With `REG_OUT=1`, `funcOut` changes only at a rising edge. A new `dataIn` is not visible on `funcOut` before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadTbl | input | 1 | Capture strobe for `tblIn` |
| tblIn | input | N+1 | Output value for each count of ones, bit c for count c |
| dataIn | input | N | The inputs of the symmetric function |
| layerOut | output | 2*(N/2+1) | First-layer outputs, lower/upper pair per run |
| funcOut | output | 1 | Function value (registered when REG_OUT=1) |

## Verification
The case that is hardest to reach from the ports is the one-cycle window after a load. In that window the table register already holds the new value, but the first-layer units still use the run edges of the old table. The stimulus loads a table with the inputs held steady. It samples `layerOut` between the capture edge and the rebuild edge, expecting the old pattern, and samples again after the rebuild edge, expecting the new one. Tables with runs at count 0 and count `N`, many isolated runs (parity), and no run at all are swept over every one of the 256 input patterns.

// File: rtl/lts_pkg.sv
package lts_pkg;

  typedef struct packed {
    logic rebuild;
  } ctrlStrobe_t;

  function automatic int maxRuns(input int n);
    return n / 2 + 1;
  endfunction

endpackage

// File: rtl/lts_unit.sv
module lts_unit #(
  parameter int CW = 4
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] edgeVal,
  input  logic          isUpper,
  input  logic          enable,
  output logic          fire
);
  logic signed [CW:0] margin;

  // weights +1 with bias -a (lower edge) or weights -1 with bias +b (upper edge)
  always_comb begin
    if (isUpper) margin = $signed({1'b0, edgeVal}) - $signed({1'b0, count});
    else         margin = $signed({1'b0, count}) - $signed({1'b0, edgeVal});
    fire = enable && !margin[CW];
  end
endmodule

// File: rtl/lts_ctrl.sv
module lts_ctrl import lts_pkg::*; #(
  parameter int N = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadTbl,
  input  logic [N:0]  tblIn,
  output logic [N:0]  tblReg,
  output ctrlStrobe_t strobe
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblReg         <= '0;
      strobe.rebuild <= 1'b0;
    end else begin
      if (loadTbl) tblReg <= tblIn;
      strobe.rebuild <= loadTbl;
    end
  end
endmodule

// File: rtl/lts_datapath.sv
module lts_datapath import lts_pkg::*; #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [N:0]                  tbl,
  input  logic [N-1:0]                dataIn,
  output logic [2*maxRuns(N)-1:0]     layerOut,
  output logic                        funcOut
);
  localparam int MR = maxRuns(N);
  localparam int CW = $clog2(N + 1);
  localparam int SW = $clog2(2 * MR + 2) + 2;

  logic [CW-1:0] nxtLo [MR];
  logic [CW-1:0] nxtHi [MR];
  logic [MR-1:0] nxtVld;
  logic [CW-1:0] runLo [MR];
  logic [CW-1:0] runHi [MR];
  logic [MR-1:0] runVld;
  logic [CW-1:0] onesCnt;
  logic signed [SW-1:0] acc;
  logic          sumFire;

  // locate the edges of every maximal 1-run in the count table
  always_comb begin
    int   runIdx;
    logic prevOne;
    runIdx  = 0;
    prevOne = 1'b0;
    nxtVld  = '0;
    for (int r = 0; r < MR; r++) begin
      nxtLo[r] = '0;
      nxtHi[r] = '0;
    end
    for (int i = 0; i <= N; i++) begin
      if (runIdx < MR) begin
        if (tbl[i] && !prevOne) begin
          nxtLo[runIdx]  = CW'(i);
          nxtVld[runIdx] = 1'b1;
        end
        if (tbl[i]) nxtHi[runIdx] = CW'(i);
      end
      if (!tbl[i] && prevOne) runIdx = runIdx + 1;
      prevOne = tbl[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runVld <= '0;
      for (int r = 0; r < MR; r++) begin
        runLo[r] <= '0;
        runHi[r] <= '0;
      end
    end else if (strobe.rebuild) begin
      runVld <= nxtVld;
      for (int r = 0; r < MR; r++) begin
        runLo[r] <= nxtLo[r];
        runHi[r] <= nxtHi[r];
      end
    end
  end

  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < N; i++) onesCnt = onesCnt + CW'(dataIn[i]);
  end

  // first layer: one lower-edge and one upper-edge unit per run slot
  for (genvar r = 0; r < MR; r++) begin : g_layer
    lts_unit #(.CW(CW)) uLower (
      .count(onesCnt), .edgeVal(runLo[r]), .isUpper(1'b0),
      .enable(runVld[r]), .fire(layerOut[2*r])
    );
    lts_unit #(.CW(CW)) uUpper (
      .count(onesCnt), .edgeVal(runHi[r]), .isUpper(1'b1),
      .enable(runVld[r]), .fire(layerOut[2*r+1])
    );
  end

  // output unit: unit weights, bias of -(runs + 1), sign test
  always_comb begin
    acc = -SW'(1);
    for (int r = 0; r < MR; r++) if (runVld[r]) acc = acc - SW'(1);
    for (int k = 0; k < 2 * MR; k++) acc = acc + SW'(layerOut[k]);
    sumFire = !acc[SW-1];
  end

  if (REG_OUT) begin : g_regOut
    always_ff @(posedge clk) begin
      if (!rstN) funcOut <= 1'b0;
      else       funcOut <= sumFire;
    end
  end else begin : g_combOut
    assign funcOut = sumFire;
  end
endmodule

// File: rtl/lts_symfunc_eval.sv
module lts_symfunc_eval import lts_pkg::*; #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    loadTbl,
  input  logic [N:0]              tblIn,
  input  logic [N-1:0]            dataIn,
  output logic [2*(N/2+1)-1:0]    layerOut,
  output logic                    funcOut
);
  ctrlStrobe_t strobe;
  logic [N:0]  tblQ;
  logic        rebuildPend;

  assign rebuildPend = strobe.rebuild;

  lts_ctrl #(.N(N)) uCtrl (
    .clk(clk), .rstN(rstN), .loadTbl(loadTbl), .tblIn(tblIn),
    .tblReg(tblQ), .strobe(strobe)
  );

  lts_datapath #(.N(N), .REG_OUT(REG_OUT)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tbl(tblQ),
    .dataIn(dataIn), .layerOut(layerOut), .funcOut(funcOut)
  );
endmodule

// File: rtl/lts_symfunc_chk.sv
module lts_symfunc_chk #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 loadTbl,
  input logic [N:0]           tblReg,
  input logic                 rebuild,
  input logic [2*(N/2+1)-1:0] layerOut,
  input logic                 funcOut
);
  localparam int MR = N / 2 + 1;

  logic [MR-1:0] inRun;
  for (genvar r = 0; r < MR; r++) begin : g_in
    assign inRun[r] = layerOut[2*r] & layerOut[2*r+1];
  end

  // R2: a capture is always followed by a rebuild cycle
  p_rebuild_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadTbl |=> rebuild);

  // R7: without a strobe the stored table holds
  p_table_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !loadTbl |=> $stable(tblReg));

  // R4: the count lies inside at most one run
  p_single_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(inRun));

  // R4: upper unit of a run and lower unit of the next run never fire together
  for (genvar r = 0; r + 1 < MR; r++) begin : g_gap
    p_run_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
      !(layerOut[2*r+1] && layerOut[2*(r+1)]));
  end

  // R6: an all-zero table with edges rebuilt leaves the first layer silent
  p_zero_table_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tblReg == '0 && !rebuild) |-> (layerOut == '0));

  // R3 / R8: output unit agrees with the first layer one edge later
  if (REG_OUT) begin : g_reg
    p_out_follows_layer_r3: assert property (@(posedge clk) disable iff (!rstN)
      funcOut == $past(|inRun));
  end else begin : g_comb
    p_out_follows_layer_r3: assert property (@(posedge clk) disable iff (!rstN)
      funcOut == (|inRun));
  end
endmodule

bind lts_symfunc_eval lts_symfunc_chk #(.N(N), .REG_OUT(REG_OUT)) uChk (
  .clk(clk), .rstN(rstN), .loadTbl(loadTbl), .tblReg(tblQ),
  .rebuild(rebuildPend), .layerOut(layerOut), .funcOut(funcOut)
);

// File: tb/tb_lts_symfunc_eval.sv
`timescale 1ns/1ps
module tb_lts_symfunc_eval;
  localparam int N  = 8;
  localparam int LW = 2 * (N / 2 + 1);
  localparam int NV = 12;

  // {table, inputs, expected output}
  localparam logic [17:0] VECS [NV] = '{
    {9'h0AA, 8'h01, 1'b1}, {9'h0AA, 8'h03, 1'b0}, {9'h0AA, 8'hFF, 1'b0},
    {9'h0AA, 8'h7F, 1'b1}, {9'h1E0, 8'h0F, 1'b0}, {9'h1E0, 8'h1F, 1'b1},
    {9'h1E0, 8'hFF, 1'b1}, {9'h001, 8'h00, 1'b1}, {9'h001, 8'h80, 1'b0},
    {9'h00C, 8'h05, 1'b1}, {9'h00C, 8'h07, 1'b1}, {9'h00C, 8'h0F, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadTbl = 1'b0;
  logic [N:0]    tblIn = '0;
  logic [N-1:0]  dataIn = '0;
  logic [LW-1:0] layerOut;
  logic          funcOut;
  int            checks = 0;
  int            fails = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  lts_symfunc_eval #(.N(N), .REG_OUT(1'b1)) dut (
    .clk(clk), .rstN(rstN), .loadTbl(loadTbl), .tblIn(tblIn),
    .dataIn(dataIn), .layerOut(layerOut), .funcOut(funcOut)
  );

  function automatic int ones(input logic [N-1:0] d);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(d[i]);
    return c;
  endfunction

  function automatic logic [LW-1:0] expLayer(input logic [N:0] t, input int c);
    logic [LW-1:0] e = '0;
    int r = 0;
    int lo = 0;
    for (int i = 0; i <= N; i++) begin
      if (t[i] && (i == 0 || !t[i-1])) lo = i;
      if (t[i] && (i == N || !t[i+1])) begin
        e[2*r]   = (c >= lo);
        e[2*r+1] = (c <= i);
        r++;
      end
    end
    return e;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadTable(input logic [N:0] t);
    @(negedge clk); tblIn = t; loadTbl = 1'b1;
    @(negedge clk); loadTbl = 1'b0;
    @(negedge clk);
  endtask

  task automatic evalIn(input logic [N-1:0] d);
    @(negedge clk); dataIn = d;
    @(negedge clk);
  endtask

  task automatic sweep(input string req, input logic [N:0] t);
    loadTable(t);
    for (int d = 0; d < 256; d++) begin
      evalIn(N'(d));
      check(req, 32'(funcOut), 32'(t[ones(N'(d))]));
      check(req, 32'(layerOut), 32'(expLayer(t, ones(N'(d)))));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    dataIn = 8'h5A;
    #1;
    check("R1 layer at reset", 32'(layerOut), 32'h0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 out after reset", 32'(funcOut), 32'h0);
    check("R1 layer after reset", 32'(layerOut), 32'h0);

    // vector table walk (R3)
    for (int v = 0; v < NV; v++) begin
      loadTable(VECS[v][17:9]);
      evalIn(VECS[v][8:1]);
      check("R3 vector", 32'(funcOut), 32'(VECS[v][0]));
    end

    // R2: old edges hold for one cycle after capture
    loadTable(9'h0AA);
    @(negedge clk); dataIn = 8'h01;
    @(negedge clk); tblIn = 9'h1E0; loadTbl = 1'b1;
    @(negedge clk); loadTbl = 1'b0;
    check("R2 old table in window", 32'(layerOut), 32'(expLayer(9'h0AA, 1)));
    @(negedge clk);
    check("R2 new table after rebuild", 32'(layerOut), 32'(expLayer(9'h1E0, 1)));
    @(negedge clk);
    check("R2 new function on output", 32'(funcOut), 32'h0);

    // R7: tblIn changes without a strobe are ignored
    loadTable(9'h00C);
    @(negedge clk); tblIn = 9'h1FF;
    repeat (3) @(negedge clk);
    evalIn(8'h01);
    check("R7 function unchanged", 32'(funcOut), 32'h0);
    check("R7 layer unchanged", 32'(layerOut), 32'(expLayer(9'h00C, 1)));

    // R8: registered output latency
    evalIn(8'h03);
    @(negedge clk); dataIn = 8'h0F;
    #1;
    check("R8 output held before edge", 32'(funcOut), 32'h1);
    @(negedge clk);
    check("R8 output after edge", 32'(funcOut), 32'h0);

    // exhaustive sweeps
    sweep("R3 parity", 9'h0AA);
    sweep("R3 even parity", 9'h155);
    sweep("R5 all ones", 9'h1FF);
    sweep("R5 runs at both ends", 9'h103);
    sweep("R4 middle interval", 9'h038);
    sweep("R6 all zero", 9'h000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule